// File: doc/BRIEF.md
# Trimmable 1 Hz Tick Generator

This block derives a once-per-second tick for a real-time clock from one of two slow time bases of roughly 32 kHz. The first time base is a fast crystal clock, about 3.6864 MHz, brought down by a fixed modulo-112 prescaler to about 32.914 kHz. The second is a native 32.768 kHz clock that is used without division. Both time bases arrive as single-cycle enable pulses in one system clock domain. The block creates no derived clocks.

A programmable integer divisor counts a number of source cycles for each tick. A delete count adds a fractional correction: once in every 1024 tick periods, it lengthens one period by that many extra source cycles. Both values are held in a trim register. Software can adjust the tick rate with it, to correct for crystal error and for the inexact frequency of the prescaled source. A new trim value is picked up only at a period boundary.

The trim register has its own reset domain. Only the hardware reset clears it. The watchdog reset clears every other flop, and after it the tick restarts at once with the trim value that was retained.

Top module: `hz_tick_gen`

## Requirements
- R1: A hardware reset loads the trim register with divisor 32767 in bits 15:0 and delete count 0 in bits 25:16, so `trim_q` reads 0x0007FFF. A write through `trim_wr`/`trim_wdata` appears on `trim_q` after the write cycle.
- R2: With `src_sel`=1, each tick period lasts divisor+1 `slow_en` pulses, apart from the lengthened period of R5.
- R3: With `src_sel`=0, the source is every 112th `fast_en` pulse, and each tick period lasts 112*(divisor+1) `fast_en` pulses. The input of the unselected source has no effect.
- R4: `hz` rises one clock after the source enable that closes a period. It stays high until one clock after the next source enable, which is exactly one source interval.
- R5: One period in every 1024 is lengthened by the delete count. The first period after any reset is the lengthened one.
- R6: A trim write made in the middle of a period leaves that period's length unchanged. The new value governs the period that starts at the next boundary.
- R7: A watchdog reset clears the counters, the prescaler and `hz`, but leaves the trim register unchanged. Periods after the watchdog reset use the retained trim value.
- R8: While either reset is asserted, `hz` is low from the next clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hw_rst_n | input | 1 | Hardware reset, active low, synchronous; clears everything |
| wdt_rst_n | input | 1 | Watchdog reset, active low, synchronous; clears everything except trim |
| fast_en | input | 1 | One pulse per fast crystal cycle |
| slow_en | input | 1 | One pulse per native 32.768 kHz cycle |
| src_sel | input | 1 | 1 selects the native source, 0 the prescaled fast source |
| trim_wr | input | 1 | Trim register write strobe |
| trim_wdata | input | 26 | Write data: delete count in 25:16, divisor in 15:0 |
| trim_q | output | 26 | Current trim register contents |
| hz | output | 1 | Tick, high for one source interval per period |

## Verification
The assertions assume that `fast_en` and `slow_en` are pulses qualified by the system clock, and that the trim register only changes through `trim_wr`. The one-interval check on `hz` also relies on every period being longer than one source cycle. The stimulus meets these assumptions: it holds `fast_en` high, toggles `slow_en` every clock, and always programs a divisor of at least 1. It switches `src_sel` only between measurements, and it discards the first two ticks after any change to the source or the trim value.

// File: rtl/hz_tick_gen.sv
module hz_tick_gen #(
  parameter int DIV_W    = 16,
  parameter int DEL_W    = 10,
  parameter int FRAC_W   = 10,
  parameter int PRESCALE = 112,
  parameter int RST_DIV  = 32767
) (
  input  logic                   clk,
  input  logic                   hw_rst_n,
  input  logic                   wdt_rst_n,
  input  logic                   fast_en,
  input  logic                   slow_en,
  input  logic                   src_sel,
  input  logic                   trim_wr,
  input  logic [DIV_W+DEL_W-1:0] trim_wdata,
  output logic [DIV_W+DEL_W-1:0] trim_q,
  output logic                   hz
);
  localparam int PRE_W = $clog2(PRESCALE);
  localparam int LIM_W = (DIV_W > DEL_W ? DIV_W : DEL_W) + 1;

  logic [PRE_W-1:0]  pre;
  logic [DIV_W-1:0]  trim_div, act_div;
  logic [DEL_W-1:0]  trim_del, act_del;
  logic [FRAC_W-1:0] fcnt;
  logic [LIM_W-1:0]  cnt;

  wire rst_all_n = hw_rst_n & wdt_rst_n;
  wire pre_wrap  = fast_en && (pre == PRE_W'(PRESCALE - 1));
  wire src_en    = src_sel ? slow_en : pre_wrap;
  wire [LIM_W-1:0] limit = LIM_W'(act_div) + ((fcnt == '0) ? LIM_W'(act_del) : '0);
  wire boundary  = src_en && (cnt == limit);

  assign trim_q = {trim_del, trim_div};

  always_ff @(posedge clk) begin
    if (!hw_rst_n) begin
      trim_div <= DIV_W'(RST_DIV);
      trim_del <= '0;
    end else if (trim_wr) begin
      {trim_del, trim_div} <= trim_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_all_n)   pre <= '0;
    else if (fast_en) pre <= pre_wrap ? '0 : pre + PRE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_all_n) begin
      cnt  <= '0;
      fcnt <= '0;
      hz   <= 1'b0;
      if (!hw_rst_n) begin
        act_div <= DIV_W'(RST_DIV);
        act_del <= '0;
      end else begin
        act_div <= trim_div;
        act_del <= trim_del;
      end
    end else if (src_en) begin
      if (boundary) begin
        cnt     <= '0;
        hz      <= 1'b1;
        fcnt    <= fcnt + FRAC_W'(1);
        act_div <= trim_div;
        act_del <= trim_del;
      end else begin
        cnt <= cnt + LIM_W'(1);
        hz  <= 1'b0;
      end
    end
  end

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_all_n)
    pre <= PRE_W'(PRESCALE - 1)); // R3
  AST_CNT_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_all_n)
    cnt <= limit); // R2
  AST_HZ_ONE_INTERVAL: assert property (@(posedge clk) disable iff (!rst_all_n)
    (hz && src_en && cnt != limit) |=> !hz); // R4
  AST_ACT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_all_n)
    !boundary |=> ($stable(act_div) && $stable(act_del))); // R6
  AST_TRIM_SURVIVES_WDT: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (!wdt_rst_n && !trim_wr) |=> $stable(trim_q)); // R7
  AST_HZ_LOW_IN_RESET: assert property (@(posedge clk)
    !rst_all_n |=> !hz); // R8
endmodule

// File: tb/hz_tick_gen_test.sv
module hz_tick_gen_test;
  logic clk = 1'b0;
  logic hw_rst_n = 1'b0, wdt_rst_n = 1'b1;
  logic fast_en = 1'b1, slow_en = 1'b0, src_sel = 1'b1;
  logic trim_wr = 1'b0;
  logic [25:0] trim_wdata = '0;
  logic [25:0] trim_q;
  logic hz;

  hz_tick_gen uut (.clk(clk), .hw_rst_n(hw_rst_n), .wdt_rst_n(wdt_rst_n), .fast_en(fast_en),
                   .slow_en(slow_en), .src_sel(src_sel), .trim_wr(trim_wr),
                   .trim_wdata(trim_wdata), .trim_q(trim_q), .hz(hz));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0, last_rise = 0, gap = 0, rises = 0;
  int run = 0, last_high = 0;
  logic hz_d = 1'b0;
  bit armed = 0;
  int counted = 0, nlong = 0, nbad = 0, long1 = -1, long2 = -1;

  initial forever begin
    @(negedge clk);
    slow_en = ~slow_en;
  end

  initial forever begin
    @(negedge clk);
    cyc++;
    if (hz && !hz_d) begin
      gap = cyc - last_rise;
      last_rise = cyc;
      rises++;
      if (armed && counted < 2048) begin
        if (gap == 18) begin
          nlong++;
          if (long1 < 0) long1 = counted; else if (long2 < 0) long2 = counted;
        end else if (gap != 8) nbad++;
        counted++;
      end
    end
    if (hz) run++;
    else if (hz_d) begin last_high = run; run = 0; end
    hz_d = hz;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_range(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic write_trim(int div, int del);
    @(negedge clk);
    trim_wr = 1'b1;
    trim_wdata = 26'((del << 16) | div);
    @(negedge clk);
    trim_wr = 1'b0;
  endtask

  task automatic wait_rises(int n);
    int target = rises + n;
    while (rises < target) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  localparam int NV = 5;
  localparam int VSEL[NV] = '{1, 1, 1, 0, 0};
  localparam int VDIV[NV] = '{1, 5, 9, 1, 3};
  localparam int VGAP[NV] = '{4, 12, 20, 224, 448};
  localparam int VHI [NV] = '{2, 2, 2, 112, 112};

  initial begin
    int rel;
    repeat (4) @(negedge clk);
    check("R1 reset trim", int'(trim_q), 32'h7FFF);
    check("R8 hz low in reset", int'(hz), 0);
    hw_rst_n = 1'b1;
    rel = cyc;
    wait_rises(1);
    check_range("R2 default period 32768 slow cycles", last_rise - rel, 65533, 65540);

    for (int i = 0; i < NV; i++) begin
      src_sel = VSEL[i][0];
      write_trim(VDIV[i], 0);
      check("R1 trim readback", int'(trim_q), VDIV[i]);
      wait_rises(3);
      check(VSEL[i] != 0 ? "R2 native period" : "R3 prescaled period", gap, VGAP[i]);
      check("R4 hz high length", last_high, VHI[i]);
    end

    src_sel = 1'b1;
    write_trim(3, 5);
    wait_rises(2);
    armed = 1;
    while (counted < 2048) @(negedge clk);
    armed = 0;
    check("R5 lengthened periods in 2048", nlong, 2);
    check("R5 other periods regular", nbad, 0);
    check("R5 spacing of lengthened periods", long2 - long1, 1024);

    write_trim(3, 0);
    wait_rises(3);
    wait_rises(1);
    write_trim(9, 0);
    wait_rises(1);
    check("R6 period in progress keeps old trim", gap, 8);
    wait_rises(1);
    check("R6 next period uses new trim", gap, 20);

    write_trim(3, 5);
    wait_rises(2);
    @(negedge clk);
    wdt_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 trim survives watchdog", int'(trim_q), 32'h0005_0003);
    check("R8 hz low in watchdog reset", int'(hz), 0);
    wdt_rst_n = 1'b1;
    rel = cyc;
    wait_rises(1);
    check_range("R5 first period after reset lengthened", last_rise - rel, 15, 21);
    wait_rises(1);
    check("R7 retained divisor after watchdog", gap, 8);

    @(negedge clk);
    hw_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 hz low in hardware reset", int'(hz), 0);
    check("R1 hardware reset restores trim", int'(trim_q), 32'h7FFF);
    summary();
  end
endmodule